// File: doc/BRIEF.md
# Cartesian Number-Format and Overflow Stage

This block sits on both sides of a coordinate-conversion core and handles number formats only. On the way in, it turns the two Cartesian operands from the selected external format into the core's internal two's complement. On the way out, it encodes the core's wide signed results back into the selected 16-bit format and clips any value that does not fit. A single select input picks the external format: high means two's complement, low means sign-and-magnitude, where the top bit marks a negative value and the lower 15 bits hold its size.

A mode input says which way the core is converting. When Cartesian data goes in and radius/angle comes out, the operands are converted, the radius and angle results pass through untouched, and no overflow is reported. When radius/angle goes in and Cartesian data comes out, the radius and angle operands pass through untouched, and the two Cartesian results are range-checked. An overflow flag is registered every cycle and simply follows whether either output was clipped.

Both paths have one register stage. The operands on the core side and the encoded results together with the flag all change on the clock edge after the values that produce them.

Top module: `cart_fmt_stage`

## Requirements
- R1: With rect_to_polar=1 and twos_sel=1, x_core and y_core equal x_in and y_in as they were at the previous rising edge.
- R2: With rect_to_polar=1 and twos_sel=0, an operand whose bit 15 is 1 becomes the two's complement negative of bits 14:0, and an operand whose bit 15 is 0 becomes bits 14:0. The result appears one edge later.
- R3: With rect_to_polar=1 and twos_sel=0, the operand 16'h8000 (negative zero) becomes 16'h0000.
- R4: With rect_to_polar=0, x_core and y_core take the raw x_in and y_in (radius and angle) one edge later, in either format.
- R5: With rect_to_polar=0 and twos_sel=1, a result in -32768..32767 comes out as its low 16 bits. Above 32767 it is clipped to 16'h7FFF, and below -32768 it is clipped to 16'h8000. A result of -32768 is in range.
- R6: With rect_to_polar=0 and twos_sel=0, a result in -32767..32767 comes out as a sign bit (bit 15 = 1 for negative) over a 15-bit magnitude, and zero comes out as 16'h0000. Above 32767 it is clipped to 16'h7FFF, and below -32767 it is clipped to 16'hFFFF. A result of -32768 is out of range.
- R7: With rect_to_polar=0, ovf is 1 on the edge after any cycle in which either result was out of range for the selected format, and 0 on the edge after a cycle in which both were in range.
- R8: With rect_to_polar=1, out_a and out_b take the low 16 bits of core_a and core_b unchanged one edge later, and ovf is 0.
- R9: While rst_n is 0, x_core, y_core, out_a, out_b and ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| twos_sel | input | 1 | 1 = two's complement, 0 = sign-and-magnitude |
| rect_to_polar | input | 1 | 1 = Cartesian in / polar out, 0 = polar in / Cartesian out |
| x_in | input | 16 | X operand or radius in external format |
| y_in | input | 16 | Y operand or angle in external format |
| x_core | output | 16 | Operand X or radius delivered to the core |
| y_core | output | 16 | Operand Y or angle delivered to the core |
| core_a | input | 18 | Core result: X or radius, signed |
| core_b | input | 18 | Core result: Y or angle, signed |
| out_a | output | 16 | Encoded result A |
| out_b | output | 16 | Encoded result B |
| ovf | output | 1 | Registered Cartesian overflow flag |

## Verification
Every cycle, the assertions check that no overflow is flagged after a cycle in Cartesian-to-polar mode, that a raised flag always comes with at least one clipped output code, that sign-and-magnitude output never shows the two's complement minimum code, that negative zero in is zero out, and that the polar results pass through unchanged. The exact clip values, including the asymmetric -32768 boundary in two's complement compared with sign-and-magnitude, are shown only by the bench scenarios. The same holds for the flag rising and falling as results move in and out of range, and for the encoding of each mix of format and mode. For these the bench compares the outputs against its own behavioural model.

// File: rtl/cart_fmt_pkg.sv
`timescale 1ns/1ps
package cart_fmt_pkg;
    typedef enum logic {
        FMT_SIGNMAG = 1'b0,
        FMT_TWOS    = 1'b1
    } num_fmt_e;

    localparam int LANES = 2;
endpackage

// File: rtl/cart_fmt_in_conv.sv
`timescale 1ns/1ps
module cart_fmt_in_conv
    import cart_fmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  num_fmt_e          fmt,
    input  logic              bypass,
    output logic [DATA_W-1:0] conv
);
    localparam int MAG_W = DATA_W - 1;

    logic [DATA_W-1:0] mag_ext;

    always_comb begin
        mag_ext = {1'b0, raw[MAG_W-1:0]};
        if (bypass || fmt == FMT_TWOS) begin
            conv = raw;
        end else if (raw[DATA_W-1]) begin
            conv = DATA_W'(-mag_ext);   // zero magnitude stays zero
        end else begin
            conv = mag_ext;
        end
    end
endmodule

// File: rtl/cart_fmt_out_sat.sv
`timescale 1ns/1ps
module cart_fmt_out_sat
    import cart_fmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int INT_W  = 18
) (
    input  logic signed [INT_W-1:0] val,
    input  num_fmt_e                fmt,
    input  logic                    bypass,
    output logic [DATA_W-1:0]       code,
    output logic                    oor
);
    localparam int MAG_W = DATA_W - 1;
    localparam logic signed [INT_W-1:0] POS_MAX = INT_W'((64'sd1 <<< MAG_W) - 1);
    localparam logic signed [INT_W-1:0] NEG_TC  = -POS_MAX - INT_W'(1);
    localparam logic signed [INT_W-1:0] NEG_SM  = -POS_MAX;

    logic                    hi, lo;
    logic signed [INT_W-1:0] clipped;
    logic signed [INT_W-1:0] negated;

    always_comb begin
        hi      = val > POS_MAX;
        lo      = (fmt == FMT_TWOS) ? (val < NEG_TC) : (val < NEG_SM);
        clipped = hi ? POS_MAX : (lo ? ((fmt == FMT_TWOS) ? NEG_TC : NEG_SM) : val);
        negated = -clipped;
        if (bypass) begin
            code = val[DATA_W-1:0];
            oor  = 1'b0;
        end else begin
            oor = hi | lo;
            if (fmt == FMT_TWOS || !clipped[INT_W-1]) begin
                code = clipped[DATA_W-1:0];
            end else begin
                code = {1'b1, negated[MAG_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/cart_fmt_stage.sv
`timescale 1ns/1ps
module cart_fmt_stage
    import cart_fmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int INT_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    twos_sel,
    input  logic                    rect_to_polar,
    input  logic [DATA_W-1:0]       x_in,
    input  logic [DATA_W-1:0]       y_in,
    output logic [DATA_W-1:0]       x_core,
    output logic [DATA_W-1:0]       y_core,
    input  logic signed [INT_W-1:0] core_a,
    input  logic signed [INT_W-1:0] core_b,
    output logic [DATA_W-1:0]       out_a,
    output logic [DATA_W-1:0]       out_b,
    output logic                    ovf
);
    num_fmt_e fmt;
    assign fmt = num_fmt_e'(twos_sel);

    logic [DATA_W-1:0]       in_raw  [LANES];
    logic [DATA_W-1:0]       in_conv [LANES];
    logic signed [INT_W-1:0] res_val [LANES];
    logic [DATA_W-1:0]       res_code[LANES];
    logic [LANES-1:0]        res_oor;

    assign in_raw[0]  = x_in;
    assign in_raw[1]  = y_in;
    assign res_val[0] = core_a;
    assign res_val[1] = core_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cart_fmt_in_conv #(.DATA_W(DATA_W)) u_in (
            .raw   (in_raw[g]),
            .fmt   (fmt),
            .bypass(!rect_to_polar),
            .conv  (in_conv[g])
        );
        cart_fmt_out_sat #(.DATA_W(DATA_W), .INT_W(INT_W)) u_out (
            .val   (res_val[g]),
            .fmt   (fmt),
            .bypass(rect_to_polar),
            .code  (res_code[g]),
            .oor   (res_oor[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_core <= '0;
            y_core <= '0;
            out_a  <= '0;
            out_b  <= '0;
            ovf    <= 1'b0;
        end else begin
            x_core <= in_conv[0];
            y_core <= in_conv[1];
            out_a  <= res_code[0];
            out_b  <= res_code[1];
            ovf    <= |res_oor;
        end
    end

    localparam logic [DATA_W-1:0] CODE_PMAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] CODE_TMIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] CODE_SMIN = {DATA_W{1'b1}};

    AST_RTP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        rect_to_polar |=> !ovf); // R8
    AST_OVF_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (out_a == CODE_PMAX || out_a == CODE_TMIN || out_a == CODE_SMIN ||
                 out_b == CODE_PMAX || out_b == CODE_TMIN || out_b == CODE_SMIN)); // R7
    AST_SM_NO_TMIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!twos_sel && !rect_to_polar) |=> (out_a != CODE_TMIN && out_b != CODE_TMIN)); // R6
    AST_NEGZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (!twos_sel && rect_to_polar && x_in == CODE_TMIN) |=> x_core == '0); // R3
    AST_RTP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        rect_to_polar |=> out_a == $past(core_a[DATA_W-1:0])); // R8
    AST_PTR_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        !rect_to_polar |=> y_core == $past(y_in)); // R4
endmodule

// File: tb/test_cart_fmt_stage.sv
`timescale 1ns/1ps
module test_cart_fmt_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic twos_sel = 1'b1, rect_to_polar = 1'b1;
    logic [15:0] x_in = '0, y_in = '0;
    logic signed [17:0] core_a = '0, core_b = '0;
    logic [15:0] x_core, y_core, out_a, out_b;
    logic ovf;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cart_fmt_stage i_cart_fmt_stage (
        .clk(clk), .rst_n(rst_n), .twos_sel(twos_sel), .rect_to_polar(rect_to_polar),
        .x_in(x_in), .y_in(y_in), .x_core(x_core), .y_core(y_core),
        .core_a(core_a), .core_b(core_b), .out_a(out_a), .out_b(out_b), .ovf(ovf));

    function automatic int ref_in(int raw, bit twos, bit rtp);
        int mag;
        if (!rtp || twos) return raw;
        mag = raw % 32768;
        return (raw >= 32768) ? ((65536 - mag) % 65536) : mag;
    endfunction

    function automatic int ref_out(int v, bit twos, bit rtp, output bit oor);
        int lo;
        oor = 0;
        if (rtp) return ((v % 65536) + 65536) % 65536;
        lo = twos ? -32768 : -32767;
        if (v > 32767) begin v = 32767; oor = 1; end
        if (v < lo) begin v = lo; oor = 1; end
        if (twos) return (v + 65536) % 65536;
        return (v < 0) ? (32768 - v) : v;
    endfunction

    function automatic string tag_in(int raw, bit twos, bit rtp);
        if (!rtp) return "R4";
        if (twos) return "R1";
        return (raw == 32768) ? "R3" : "R2";
    endfunction

    int exp_x = 0, exp_y = 0, exp_a = 0, exp_b = 0;
    bit exp_ovf = 0;
    string t_x = "R9", t_y = "R9", t_o = "R9", t_f = "R9";

    always @(posedge clk) begin
        bit oa, ob;
        int ea, eb;
        if (!rst_n) begin
            exp_x <= 0; exp_y <= 0; exp_a <= 0; exp_b <= 0; exp_ovf <= 0;
            t_x <= "R9"; t_y <= "R9"; t_o <= "R9"; t_f <= "R9";
        end else begin
            ea = ref_out(int'(core_a), twos_sel, rect_to_polar, oa);
            eb = ref_out(int'(core_b), twos_sel, rect_to_polar, ob);
            exp_x <= ref_in(int'(x_in), twos_sel, rect_to_polar);
            exp_y <= ref_in(int'(y_in), twos_sel, rect_to_polar);
            exp_a <= ea; exp_b <= eb; exp_ovf <= oa | ob;
            t_x <= tag_in(int'(x_in), twos_sel, rect_to_polar);
            t_y <= tag_in(int'(y_in), twos_sel, rect_to_polar);
            t_o <= rect_to_polar ? "R8" : (twos_sel ? "R5" : "R6");
            t_f <= rect_to_polar ? "R8" : "R7";
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            check(t_x, "x_core", int'(x_core), exp_x);
            check(t_y, "y_core", int'(y_core), exp_y);
            check(t_o, "out_a", int'(out_a), exp_a);
            check(t_o, "out_b", int'(out_b), exp_b);
            check(t_f, "ovf", int'(ovf), int'(exp_ovf));
        end
    end

    task automatic apply(bit tw, bit rtp, int x, int y, int a, int b);
        @(negedge clk);
        twos_sel = tw; rect_to_polar = rtp;
        x_in = 16'(x); y_in = 16'(y);
        core_a = 18'(a); core_b = 18'(b);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        apply(1, 0, 16'h1234, 16'h4321, 200000, -200000);  // R9 reset holds zero
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(1, 1, 16'hFFFB, 16'h04D2, 5, 7);            // R1, R8
        apply(0, 1, 16'h8005, 16'h0003, 70000, -70000);   // R2, R8 no ovf
        apply(0, 1, 16'h8000, 16'hFFFF, 0, 0);            // R3
        apply(1, 0, 16'hB504, 16'hABCD, 32767, -32768);   // R4, R5 in range
        apply(0, 0, 16'hB505, 16'h8000, 0, 0);            // R4 raw in sm
        apply(1, 0, 0, 0, 32768, 0);                      // R5 +clip, R7 rise
        apply(1, 0, 0, 0, -32769, 100);                   // R5 -clip
        apply(1, 0, 0, 0, 12, -12);                       // R7 fall
        apply(0, 0, 0, 0, -32768, 5);                     // R6 -32768 overflows
        apply(0, 0, 0, 0, -32767, -1);                    // R6 in range
        apply(0, 0, 0, 0, 0, 40000);                      // R6 +clip
        apply(0, 0, 0, 0, -131072, 131071);               // R6 extremes
        apply(0, 0, 0, 0, 1, 2);                          // R7 fall
        apply(1, 1, 0, 0, 131071, -131072);               // R8 bypass no ovf
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[0], lfsr[1], int'(lfsr), int'({lfsr[7:0], lfsr[15:8]}),
                  int'($signed({lfsr[2:1], lfsr})), int'($signed({lfsr[4:3], ~lfsr})));
        end
        apply(1, 1, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule